// File: doc/BRIEF.md
# Timed ADC Conversion Trigger

This block paces an analog-to-digital converter at a fixed rate with no software in the loop. Two free-running timers count the system clock. When the trigger mode is selected, the chosen timer is compared against a programmable match value. On a match, the block does two things in the same clock edge: it sends the converter a one-cycle start pulse and returns the timer to zero. The spacing between samples therefore depends only on the match value, and interrupt latency has no effect on it. For example, a match value of 12499 at a 100 MHz clock gives one start every 125 µs, which is 8 kHz.

The block also tracks each conversion. A busy bit is high from the start pulse until the converter reports done. When done arrives, the block latches the converted word and raises a single completion flag, which stays set until software clears it. The latched word is presented as a high byte and a low byte. The converter itself is outside the block. It is expected to answer each start with a one-cycle done strobe and a data word after a fixed latency.

The converter interface is a plain strobe pair. There is no back-pressure in either direction: a start is never held off by the converter, and a done strobe is never stalled. If a trigger arrives while a conversion is still busy, the start is dropped and a sticky overrun bit records the loss. All other pins are level control and status.

Top module: `sample_trigger_top`

## Requirements
- R1: When `mode` equals 4'b1011 (trigger mode), a match occurs on any cycle where the selected timer equals `cmp_val`.
- R2: A match returns the selected timer to zero on the next cycle. Consecutive matches are therefore exactly `cmp_val`+1 cycles apart.
- R3: `tmr_sel`=0 selects timer 0 for comparison and reload, and `tmr_sel`=1 selects timer 1. Both timers count on every cycle, and the unselected timer is never reloaded.
- R4: With any `mode` value other than 4'b1011, no `adc_start` is issued and both timers wrap at their full width.
- R5: A match with `adc_en`=0 issues no `adc_start` and leaves `go_busy` low.
- R6: A match with `adc_en`=1 and `go_busy`=0 raises `adc_start` for exactly one cycle, on the cycle after the match. `go_busy` rises with it and stays high until `adc_done` is seen.
- R7: `adc_done` while `go_busy` is high does three things: it clears `go_busy`, latches `adc_data`, and sets `irq_flag`. `irq_flag` stays set until `irq_clr`. If `adc_done` and `irq_clr` arrive in the same cycle, the set wins.
- R8: A match with `adc_en`=1 while `go_busy` is high issues no start and sets `overrun`. `overrun` stays set until reset.
- R9: `res_lo` is bits 7:0 of the latched word. `res_hi` is the remaining upper bits, zero-extended. A newer result overwrites the held one even while `irq_flag` is still set.
- R10: After reset, `adc_start`, `go_busy`, `irq_flag`, `overrun`, `res_hi` and `res_lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_val | input | TMR_W | Match value; sample period is this plus one cycles |
| mode | input | 4 | Compare mode; 4'b1011 is trigger mode |
| adc_en | input | 1 | Allows a match to start a conversion |
| tmr_sel | input | 1 | Chooses timer 0 or timer 1 as the trigger source |
| irq_clr | input | 1 | Clears the completion flag |
| adc_done | input | 1 | One-cycle done strobe from the converter |
| adc_data | input | RES_W | Conversion word, valid with adc_done |
| adc_start | output | 1 | One-cycle start-of-conversion pulse |
| go_busy | output | 1 | Conversion in progress |
| irq_flag | output | 1 | Conversion complete, held until cleared |
| overrun | output | 1 | Sticky: a trigger was lost while busy |
| res_hi | output | 8 | Upper bits of the latched result, zero-extended |
| res_lo | output | 8 | Lower 8 bits of the latched result |

## Verification
The bench measures the spacing between start pulses for two match values and for both timers. A design that skips the reload, or compares against the wrong timer, shows a spacing of the full timer width instead of the match value plus one.

It then checks the cases where no start may appear: a mode code one bit away from trigger mode, and trigger mode with the enable bit cleared. A design that decodes the mode loosely, or ignores the enable, would keep sampling in these cases.

It stretches the converter latency past one sample period. A correct design skips every other trigger, giving a doubled spacing, and raises overrun. A design that restarts the converter while busy shows the original spacing.

Finally, it leaves the completion flag uncleared across several conversions. The flag must stay set, and the held result must be the newest word rather than the first one.

// File: rtl/sample_trig_pkg.sv
package sample_trig_pkg;
  localparam logic [3:0] MODE_TRIGGER = 4'b1011;
  localparam int unsigned N_TIMERS = 2;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (reload) count <= '0;
    else             count <= count + 1'b1;
  end
endmodule

// File: rtl/trig_compare.sv
module trig_compare
  import sample_trig_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [3:0]   mode,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp_val,
  output logic         hit
);
  always_comb hit = (mode == MODE_TRIGGER) && (count == cmp_val);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             adc_en,
  input  logic             adc_done,
  input  logic [RES_W-1:0] adc_data,
  input  logic             irq_clr,
  output logic             adc_start,
  output logic             go_busy,
  output logic             irq_flag,
  output logic             overrun,
  output logic [RES_W-1:0] result
);
  logic launch, lost, accept;

  always_comb begin
    launch = hit && adc_en && !go_busy;
    lost   = hit && adc_en && go_busy;
    accept = go_busy && adc_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adc_start <= 1'b0;
      go_busy   <= 1'b0;
      irq_flag  <= 1'b0;
      overrun   <= 1'b0;
      result    <= '0;
    end else begin
      adc_start <= launch;
      if (launch)      go_busy <= 1'b1;
      else if (accept) go_busy <= 1'b0;
      if (lost) overrun <= 1'b1;
      if (accept) begin
        result   <= adc_data;
        irq_flag <= 1'b1;
      end else if (irq_clr) begin
        irq_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sample_trigger_top.sv
module sample_trigger_top
  import sample_trig_pkg::*;
#(
  parameter int unsigned TMR_W = 16,
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] cmp_val,
  input  logic [3:0]       mode,
  input  logic             adc_en,
  input  logic             tmr_sel,
  input  logic             irq_clr,
  input  logic             adc_done,
  input  logic [RES_W-1:0] adc_data,
  output logic             adc_start,
  output logic             go_busy,
  output logic             irq_flag,
  output logic             overrun,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);
  localparam int unsigned HI_BITS = RES_W - 8;

  logic [TMR_W-1:0] tcount [N_TIMERS];
  logic [TMR_W-1:0] sel_count;
  logic             hit;
  logic [RES_W-1:0] result;

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    tmr_counter #(.W(TMR_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (hit && (32'(tmr_sel) == g)),
      .count  (tcount[g])
    );
  end

  always_comb sel_count = tcount[tmr_sel];

  trig_compare #(.W(TMR_W)) u_cmp (
    .mode    (mode),
    .count   (sel_count),
    .cmp_val (cmp_val),
    .hit     (hit)
  );

  conv_sequencer #(.RES_W(RES_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .adc_en    (adc_en),
    .adc_done  (adc_done),
    .adc_data  (adc_data),
    .irq_clr   (irq_clr),
    .adc_start (adc_start),
    .go_busy   (go_busy),
    .irq_flag  (irq_flag),
    .overrun   (overrun),
    .result    (result)
  );

  always_comb res_lo = result[7:0];

  if (HI_BITS >= 8) begin : g_hi_full
    always_comb res_hi = result[RES_W-1 -: 8];
  end else begin : g_hi_pad
    always_comb res_hi = {{(8 - HI_BITS){1'b0}}, result[RES_W-1:8]};
  end
endmodule

// File: rtl/sample_trigger_chk.sv
module sample_trigger_chk
  import sample_trig_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode,
  input logic       adc_en,
  input logic       adc_done,
  input logic       irq_clr,
  input logic       adc_start,
  input logic       go_busy,
  input logic       irq_flag,
  input logic       overrun
);
  a_r4_no_start_other_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_TRIGGER) |=> !adc_start);

  a_r5_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |=> !adc_start);

  a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> go_busy);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (go_busy && adc_done) |=> (irq_flag && !go_busy));

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !(go_busy && adc_done)) |=> !irq_flag);

  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go_busy |=> !adc_start);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind sample_trigger_top sample_trigger_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .adc_en    (adc_en),
  .adc_done  (adc_done),
  .irq_clr   (irq_clr),
  .adc_start (adc_start),
  .go_busy   (go_busy),
  .irq_flag  (irq_flag),
  .overrun   (overrun)
);

// File: tb/sample_trigger_top_tb_top.sv
module sample_trigger_top_tb_top;
  localparam int TW = 10;
  localparam int RW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] cmp_val = '0;
  logic [3:0]    mode = 4'b0000;
  logic          adc_en = 1'b0;
  logic          tmr_sel = 1'b0;
  logic          irq_clr = 1'b0;
  logic          adc_done = 1'b0;
  logic [RW-1:0] adc_data = '0;
  logic          adc_start, go_busy, irq_flag, overrun;
  logic [7:0]    res_hi, res_lo;

  always #5 clk = ~clk;

  sample_trigger_top #(.TMR_W(TW), .RES_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_val(cmp_val), .mode(mode), .adc_en(adc_en),
    .tmr_sel(tmr_sel), .irq_clr(irq_clr), .adc_done(adc_done), .adc_data(adc_data),
    .adc_start(adc_start), .go_busy(go_busy), .irq_flag(irq_flag), .overrun(overrun),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(string req, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Converter model and scoreboard driver side
  int            lat = 20;
  int            cd = 0;
  bit            pending = 1'b0;
  int            seq = 0;
  logic [RW-1:0] val;
  logic [RW-1:0] exp_q[$];

  initial forever begin
    @(negedge clk);
    adc_done = 1'b0;
    if (pending) begin
      if (cd <= 1) begin
        adc_data = val;
        adc_done = 1'b1;
        exp_q.push_back(val);
        pending = 1'b0;
      end else cd--;
    end
    if (adc_start) begin
      pending = 1'b1;
      cd = lat;
      seq++;
      val = RW'((seq * 263 + 17) % 1024);
    end
  end

  // Start-interval monitor
  int cyc = 0, last_t = 0, last_iv = 0, nstarts = 0;
  initial forever begin
    @(negedge clk);
    cyc++;
    if (adc_start) begin
      last_iv = cyc - last_t;
      last_t = cyc;
      nstarts++;
    end
  end

  // Result monitor: pops expected words, compares, clears the flag (R7, R9)
  bit auto_clr = 1'b1;
  initial forever begin
    @(negedge clk);
    if (irq_clr) irq_clr = 1'b0;
    else if (auto_clr && irq_flag) begin
      if (exp_q.size() == 0) check("R7 unexpected irq", 1'b0, 1, 0);
      else begin
        logic [RW-1:0] e;
        e = exp_q.pop_front();
        check("R9 res_lo", res_lo == e[7:0], res_lo, e[7:0]);
        check("R9 res_hi", res_hi == 8'(e >> 8), res_hi, 8'(e >> 8));
      end
      irq_clr = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check("watchdog", 1'b0, 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 adc_start", adc_start == 0, adc_start, 0);
    check("R10 go_busy", go_busy == 0, go_busy, 0);
    check("R10 irq_flag", irq_flag == 0, irq_flag, 0);
    check("R10 overrun", overrun == 0, overrun, 0);
    check("R10 result", {res_hi, res_lo} == 0, {res_hi, res_lo}, 0);
    rst_n = 1'b1;

    // R1 R2: trigger mode, timer 0, period cmp+1
    mode = 4'b1011; adc_en = 1'b1; tmr_sel = 1'b0; cmp_val = 49;
    repeat (400) @(negedge clk);
    check("R2 period timer0", last_iv == 50, last_iv, 50);
    check("R1 starts seen", nstarts >= 6, nstarts, 6);
    // R6: busy across conversion
    while (!adc_start) @(negedge clk);
    check("R6 busy at start", go_busy == 1, go_busy, 1);
    repeat (lat + 2) @(negedge clk);
    check("R6 busy drops after done", go_busy == 0, go_busy, 0);

    // R3: timer 1 source
    tmr_sel = 1'b1; cmp_val = 29;
    repeat (1300) @(negedge clk);
    check("R3 period timer1", last_iv == 30, last_iv, 30);

    // R4: other mode codes
    mode = 4'b1010; n0 = nstarts;
    repeat (1100) @(negedge clk);
    check("R4 no start mode 1010", nstarts == n0, nstarts - n0, 0);
    mode = 4'b0011;
    repeat (1100) @(negedge clk);
    check("R4 no start mode 0011", nstarts == n0, nstarts - n0, 0);

    // R5: enable clear
    mode = 4'b1011; adc_en = 1'b0;
    repeat (1200) @(negedge clk);
    check("R5 no start disabled", nstarts == n0, nstarts - n0, 0);
    check("R5 busy low", go_busy == 0, go_busy, 0);

    // R7 R9: flag held, newest result kept
    adc_en = 1'b1; tmr_sel = 1'b0; cmp_val = 49;
    repeat (1200) @(negedge clk);
    auto_clr = 1'b0;
    repeat (300) @(negedge clk);
    check("R7 flag held", irq_flag == 1, irq_flag, 1);
    check("R9 newest lo", res_lo == exp_q[$][7:0], res_lo, exp_q[$][7:0]);
    check("R9 newest hi", res_hi == 8'(exp_q[$] >> 8), res_hi, 8'(exp_q[$] >> 8));
    while (!adc_start) @(negedge clk);
    exp_q.delete();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R7 flag cleared", irq_flag == 0, irq_flag, 0);
    auto_clr = 1'b1;
    check("R8 no overrun yet", overrun == 0, overrun, 0);

    // R8: latency longer than period
    lat = 80;
    repeat (500) @(negedge clk);
    check("R8 overrun set", overrun == 1, overrun, 1);
    check("R8 skipped trigger doubles period", last_iv == 100, last_iv, 100);

    repeat (150) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule